// File: doc/BRIEF.md
# Pop-free stepped volume controller

This block governs a 6-bit main volume code. Each code step is 2 dB. Software places a target code on the gain register input. The block then moves an internal "applied gain" code toward that target. The analog attenuator that turns the code into a level lies outside this block; it consumes the applied code and a crossfade weight.

In soft mode, each change occupies a transition window. The window is counted in sample periods, and the per-sample tick marks each period. The target is captured when a window opens, so writes that arrive during the window wait until it closes. When the window closes, the applied code takes the captured target. The block then compares the applied code with the register. If the two differ, the next window opens on the same clock edge, and any values written in between are skipped. In hard mode the applied code tracks the register one clock later, with no window. A standby input presents unity gain on a separate effective-gain output without disturbing anything else.

Top module: `vr_vol_ramp`

## Requirements
- R1: After reset, gain_act and gain_eff are 0x00 (mute), busy is 0 and xfade is all ones.
- R2: While soft_en is 0, gain_act equals the (limited) gain_reg value of the previous clock edge. busy is 0, which also aborts any open window.
- R3: While soft_en is 1 and no window is open, a limited gain_reg that differs from gain_act opens a window on the next edge: busy goes to 1 and gain_act is held.
- R4: win_sel values 0, 1, 2 and 3 make a window last 256, 512, 1024 and 2048 sample ticks. Only cycles with sample_tick at 1 count. gain_act changes on the edge that consumes the last tick.
- R5: The target is captured only when a window opens. At the window's end, gain_act takes that target. If the current gain_reg differs from it, a new window toward the current gain_reg opens at once and busy stays 1; intermediate writes are skipped.
- R6: win_sel is captured when a window opens; a change during the window affects only later windows.
- R7: During a window, xfade equals the ticks consumed, scaled so that the window spans 0 to 255 (ticks × 256 / window length). Outside a window, xfade is 255.
- R8: While standby is 1, gain_eff is 0x1F (0 dB) and gain_act and the windowing continue unchanged. While standby is 0, gain_eff equals gain_act.
- R9: Codes 0x23 to 0x3F are treated as 0x22 (+6 dB). Code 0x1F is 0 dB, each lower code is 2 dB less down to 0x01 (−60 dB), and 0x00 is mute.
- R10: busy is 0 whenever soft mode has settled, that is, when gain_act equals the limited gain_reg and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One pulse per audio sample period |
| gain_reg | input | 6 | Target volume code written by software |
| soft_en | input | 1 | 1: windowed transitions, 0: immediate |
| win_sel | input | 2 | Window length select |
| standby | input | 1 | Forces unity on gain_eff |
| gain_act | output | 6 | Applied volume code |
| gain_eff | output | 6 | Code after the standby override |
| busy | output | 1 | A transition window is open |
| xfade | output | 8 | Crossfade weight within the window |

## Verification
The hardest case to reach is a compare at the end of a window that finds a register value newer than the captured target. That case has to open a second window on the very edge where the first one closes. Several writes must land inside one window, and the bench must show that the middle value never appears on gain_act. The directed stimulus writes three codes at fixed offsets into a 256-tick window. It counts the ticks issued while busy, so it can confirm both change points and the skip. Random traffic then repeats this with irregular ticks and window selects against a reference model.

// File: rtl/vr_pkg.sv
package vr_pkg;
   localparam int VR_CODE_W     = 6;
   localparam int VR_TOP_CODE   = 'h22;
   localparam int VR_UNITY_CODE = 'h1F;
   localparam int VR_BASE_LOG2  = 8;
   localparam int VR_SEL_W      = 2;
   localparam int VR_WT_W       = 8;
endpackage

// File: rtl/vr_code_clamp.sv
module vr_code_clamp #(
   parameter int CODE_W = vr_pkg::VR_CODE_W,
   parameter logic [CODE_W-1:0] TOP_CODE = CODE_W'(vr_pkg::VR_TOP_CODE),
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-1:0] code_o
);
   generate
      if (CLAMP_EN) begin : g_limit
         assign code_o = (code_i > TOP_CODE) ? TOP_CODE : code_i;
      end else begin : g_pass
         assign code_o = code_i;
      end
   endgenerate
endmodule

// File: rtl/vr_win_timer.sv
module vr_win_timer #(
   parameter int BASE_LOG2 = vr_pkg::VR_BASE_LOG2,
   parameter int SEL_W     = vr_pkg::VR_SEL_W,
   parameter int WT_W      = vr_pkg::VR_WT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel_in,
   output logic             last,
   output logic [WT_W-1:0]  weight
);
   localparam int NSEL  = 1 << SEL_W;
   localparam int CNT_W = BASE_LOG2 + NSEL - 1;
   localparam int SH_W  = SEL_W + 1;
   localparam int WSH_W = $clog2(CNT_W + 1) + 1;

   generate
      if (WT_W > BASE_LOG2) begin : g_bad_wt
         $error("vr_win_timer: WT_W must not exceed BASE_LOG2");
      end
      if (SEL_W < 1) begin : g_bad_sel
         $error("vr_win_timer: SEL_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] sel_q;
   logic [SH_W-1:0]  lim_sh;
   logic [CNT_W-1:0] lim;
   logic [WSH_W-1:0] wsh;
   logic [CNT_W-1:0] scaled;

   // terminal count: all ones of the selected window length
   assign lim_sh = SH_W'(NSEL - 1) - {1'b0, sel_q};
   assign lim    = {CNT_W{1'b1}} >> lim_sh;
   assign last   = run & tick & (cnt_q == lim);

   assign wsh    = WSH_W'(BASE_LOG2 - WT_W) + WSH_W'(sel_q);
   assign scaled = cnt_q >> wsh;
   assign weight = run ? scaled[WT_W-1:0] : {WT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sel_q <= '0;
      end else if (load) begin
         cnt_q <= '0;
         sel_q <= sel_in;
      end else if (run && tick) begin
         cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/vr_vol_ramp.sv
module vr_vol_ramp #(
   parameter int CODE_W = vr_pkg::VR_CODE_W,
   parameter logic [CODE_W-1:0] TOP_CODE   = CODE_W'(vr_pkg::VR_TOP_CODE),
   parameter logic [CODE_W-1:0] UNITY_CODE = CODE_W'(vr_pkg::VR_UNITY_CODE),
   parameter int BASE_LOG2 = vr_pkg::VR_BASE_LOG2,
   parameter int SEL_W     = vr_pkg::VR_SEL_W,
   parameter int WT_W      = vr_pkg::VR_WT_W,
   parameter bit CLAMP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_tick,
   input  logic [CODE_W-1:0] gain_reg,
   input  logic              soft_en,
   input  logic [SEL_W-1:0]  win_sel,
   input  logic              standby,
   output logic [CODE_W-1:0] gain_act,
   output logic [CODE_W-1:0] gain_eff,
   output logic              busy,
   output logic [WT_W-1:0]   xfade
);
   generate
      if (UNITY_CODE > TOP_CODE) begin : g_bad_unity
         $error("vr_vol_ramp: UNITY_CODE above TOP_CODE");
      end
   endgenerate

   logic [CODE_W-1:0] creg;
   logic [CODE_W-1:0] act_q, act_d;
   logic [CODE_W-1:0] tgt_q, tgt_d;
   logic              busy_q, busy_d;
   logic              win_load;
   logic              win_last;

   vr_code_clamp #(
      .CODE_W(CODE_W), .TOP_CODE(TOP_CODE), .CLAMP_EN(CLAMP_EN)
   ) u_clamp (
      .code_i(gain_reg),
      .code_o(creg)
   );

   vr_win_timer #(
      .BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W), .WT_W(WT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (win_load),
      .run   (busy_q),
      .tick  (sample_tick),
      .sel_in(win_sel),
      .last  (win_last),
      .weight(xfade)
   );

   always_comb begin
      act_d    = act_q;
      tgt_d    = tgt_q;
      busy_d   = busy_q;
      win_load = 1'b0;
      if (!soft_en) begin
         act_d  = creg;
         tgt_d  = creg;
         busy_d = 1'b0;
      end else if (!busy_q) begin
         if (creg != act_q) begin
            win_load = 1'b1;
            tgt_d    = creg;
            busy_d   = 1'b1;
         end
      end else if (win_last) begin
         act_d = tgt_q;
         if (creg != tgt_q) begin
            win_load = 1'b1;
            tgt_d    = creg;
         end else begin
            busy_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= '0;
         tgt_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         act_q  <= act_d;
         tgt_q  <= tgt_d;
         busy_q <= busy_d;
      end
   end

   assign gain_act = act_q;
   assign gain_eff = standby ? UNITY_CODE : act_q;
   assign busy     = busy_q;
endmodule

// File: rtl/vr_vol_ramp_chk.sv
module vr_vol_ramp_chk #(
   parameter int CODE_W = 6,
   parameter logic [CODE_W-1:0] TOP_CODE   = CODE_W'(34),
   parameter logic [CODE_W-1:0] UNITY_CODE = CODE_W'(31),
   parameter int WT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sample_tick,
   input logic [CODE_W-1:0] gain_reg,
   input logic              soft_en,
   input logic              standby,
   input logic [CODE_W-1:0] gain_act,
   input logic [CODE_W-1:0] gain_eff,
   input logic              busy,
   input logic [WT_W-1:0]   xfade
);
   a_r2_hard_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_en && gain_reg <= TOP_CODE) |=> (gain_act == $past(gain_reg)));

   a_r2_hard_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_en |=> !busy);

   a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_en && busy && !sample_tick) |=> $stable(gain_act));

   a_r3_open_window: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_en && !busy && gain_reg <= TOP_CODE && gain_reg != gain_act) |=> busy);

   a_r7_idle_full: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (xfade == {WT_W{1'b1}}));

   a_r8_standby_unity: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> (gain_eff == UNITY_CODE));

   a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      gain_act <= TOP_CODE);
endmodule

bind vr_vol_ramp vr_vol_ramp_chk #(
   .CODE_W(CODE_W), .TOP_CODE(TOP_CODE), .UNITY_CODE(UNITY_CODE), .WT_W(WT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .gain_reg(gain_reg),
   .soft_en(soft_en), .standby(standby), .gain_act(gain_act),
   .gain_eff(gain_eff), .busy(busy), .xfade(xfade)
);

// File: tb/vr_vol_ramp_test.sv
module vr_vol_ramp_test;
   logic       clk = 1'b0;
   logic       rst_n, sample_tick, soft_en, standby;
   logic [5:0] gain_reg;
   logic [1:0] win_sel;
   logic [5:0] gain_act, gain_eff;
   logic       busy;
   logic [7:0] xfade;

   always #5 clk = ~clk;

   vr_vol_ramp uut (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .gain_reg(gain_reg),
      .soft_en(soft_en), .win_sel(win_sel), .standby(standby),
      .gain_act(gain_act), .gain_eff(gain_eff), .busy(busy), .xfade(xfade)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit cmp_on = 0;
   int tick_mode = 0;
   bit tick_ph = 0;
   int issued = 0;
   int snap = 0;
   logic [5:0] o_act, o_eff;
   logic       o_busy;
   logic [7:0] o_x;

   // reference model built from the requirements
   int m_act, m_tgt, m_cnt, m_sel, m_c;
   bit m_busy;

   function automatic int limit_code(input int c);
      return (c > 'h22) ? 'h22 : c;
   endfunction

   function automatic int win_ticks(input int s);
      return 256 << s;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_tgt = 0; m_cnt = 0; m_sel = 0; m_busy = 0;
      end else begin
         m_c = limit_code(int'(gain_reg));
         if (!soft_en) begin
            m_act = m_c; m_busy = 0;
         end else if (!m_busy) begin
            if (m_c != m_act) begin
               m_busy = 1; m_tgt = m_c; m_cnt = 0; m_sel = int'(win_sel);
            end
         end else if (sample_tick) begin
            if (m_cnt == win_ticks(m_sel) - 1) begin
               m_act = m_tgt;
               if (m_c != m_tgt) begin
                  m_tgt = m_c; m_cnt = 0; m_sel = int'(win_sel);
               end else begin
                  m_busy = 0;
               end
            end else begin
               m_cnt = m_cnt + 1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      int ex;
      @(negedge clk);
      o_act = gain_act; o_eff = gain_eff; o_busy = busy; o_x = xfade;
      snap = issued;
      if (cmp_on) begin
         ex = m_busy ? ((m_cnt >> m_sel) & 255) : 255;
         chk(int'(o_act) == m_act, "R3 gain_act vs model", o_act, m_act);
         chk(o_busy == m_busy, "R10 busy vs model", o_busy, m_busy);
         chk(int'(o_x) == ex, "R7 xfade vs model", o_x, ex);
         chk(int'(o_eff) == (standby ? 'h1F : m_act), "R8 gain_eff vs model",
             o_eff, standby ? 'h1F : m_act);
      end
      if (tick_mode == 0) begin
         tick_ph = ~tick_ph;
         sample_tick = tick_ph;
      end else begin
         sample_tick = ($urandom % 3) == 0;
      end
      if (o_busy && sample_tick) issued++;
   endtask

   task automatic measure(input logic [1:0] sel, input logic [5:0] code,
                          input bit swap_sel, output int t);
      win_sel = sel; gain_reg = code; issued = 0; t = -1;
      for (int k = 0; k < 6000; k++) begin
         step();
         if (k == 10 && swap_sel) win_sel = ~sel;
         if (o_act == code) begin
            t = snap;
            break;
         end
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int t, nchg, prev;
      bit seen1d, x_done;
      void'($urandom(32'd2718));
      rst_n = 0; gain_reg = 0; soft_en = 1; win_sel = 0; standby = 0; sample_tick = 0;
      repeat (4) step();
      chk(o_act == 0, "R1 reset gain_act", o_act, 0);
      chk(o_eff == 0, "R1 reset gain_eff", o_eff, 0);
      chk(o_busy == 0, "R1 reset busy", o_busy, 0);
      chk(o_x == 8'hFF, "R1 reset xfade", o_x, 255);
      rst_n = 1;
      step();
      cmp_on = 1;

      // R2 hard mode, R9 code limit
      soft_en = 0; gain_reg = 6'h1F; step();
      chk(o_act == 6'h1F, "R2 hard follow", o_act, 'h1F);
      chk(o_busy == 0, "R2 hard busy", o_busy, 0);
      gain_reg = 6'h3F; step();
      chk(o_act == 6'h22, "R9 limit 0x3F", o_act, 'h22);
      gain_reg = 6'h2A; step();
      chk(o_act == 6'h22, "R9 limit 0x2A", o_act, 'h22);
      gain_reg = 6'h1F; step();
      soft_en = 1; step(); step();
      chk(o_busy == 0, "R10 settled", o_busy, 0);

      // R3 R4 R5 R7: writes during a window, middle value skipped
      win_sel = 0; gain_reg = 6'h1E; issued = 0;
      nchg = 0; prev = 'h1F; seen1d = 0; x_done = 0;
      for (int k = 0; k < 3000; k++) begin
         step();
         if (k == 0) begin
            chk(o_busy == 1, "R3 window opens", o_busy, 1);
            chk(o_act == 6'h1F, "R3 held at open", o_act, 'h1F);
         end
         if (k == 5) gain_reg = 6'h1D;
         if (k == 20) gain_reg = 6'h1C;
         if (snap == 128 && !x_done && nchg == 0) begin
            chk(o_x == 8'd128, "R7 weight mid window", o_x, 128);
            x_done = 1;
         end
         if (o_act == 6'h1D) seen1d = 1;
         if (int'(o_act) != prev) begin
            nchg++;
            if (nchg == 1) begin
               chk(o_act == 6'h1E, "R5 first target", o_act, 'h1E);
               chk(snap == 256, "R4 sel0 length", snap, 256);
               chk(o_busy == 1, "R5 back-to-back window", o_busy, 1);
            end else begin
               chk(o_act == 6'h1C, "R5 second target", o_act, 'h1C);
               chk(snap == 512, "R5 second window end", snap, 512);
            end
            prev = int'(o_act);
         end
         if (nchg >= 2 && !o_busy) break;
      end
      chk(seen1d == 0, "R5 0x1D skipped", seen1d, 0);
      chk(nchg == 2, "R5 change count", nchg, 2);

      // R4 window lengths, R6 select captured at open
      measure(2'd1, 6'h10, 1'b0, t); chk(t == 512, "R4 sel1 length", t, 512);
      measure(2'd2, 6'h12, 1'b0, t); chk(t == 1024, "R4 sel2 length", t, 1024);
      measure(2'd3, 6'h08, 1'b0, t); chk(t == 2048, "R4 sel3 length", t, 2048);
      step(); step();
      chk(o_busy == 0, "R10 idle after window", o_busy, 0);
      measure(2'd0, 6'h0A, 1'b1, t); chk(t == 256, "R6 select held", t, 256);
      step(); step();

      // R8 standby override
      win_sel = 0; gain_reg = 6'h14; standby = 1; step(); step();
      chk(o_eff == 6'h1F, "R8 standby unity", o_eff, 'h1F);
      chk(o_busy == 1, "R8 window runs in standby", o_busy, 1);
      for (int k = 0; k < 1000; k++) begin
         step();
         if (o_act == 6'h14) break;
      end
      chk(o_act == 6'h14, "R8 gain_act advances", o_act, 'h14);
      chk(o_eff == 6'h1F, "R8 still unity", o_eff, 'h1F);
      standby = 0; step();
      chk(o_eff == 6'h14, "R8 release", o_eff, 'h14);

      // R2 hard mode aborts an open window
      gain_reg = 6'h05; step(); step();
      chk(o_busy == 1, "R3 window open before abort", o_busy, 1);
      soft_en = 0; step();
      chk(o_act == 6'h05, "R2 abort follow", o_act, 'h05);
      chk(o_busy == 0, "R2 abort busy", o_busy, 0);
      soft_en = 1; step();

      // constrained random phase against the model
      tick_mode = 1;
      for (int k = 0; k < 30000; k++) begin
         step();
         if ($urandom % 200 == 0) gain_reg = 6'($urandom % 64);
         if ($urandom % 300 == 0) win_sel = 2'($urandom % 4);
         if ($urandom % 500 == 0) standby = ~standby;
         if ($urandom % 2500 == 0) soft_en = ~soft_en;
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule